// File: doc/BRIEF.md
# Single-to-Half Precision Rounding Encoder

This block takes a 32-bit single-precision floating-point word and narrows it to a 16-bit half-precision word. The rounding mode is fixed at round-to-nearest with ties to even. A new input can be accepted on every clock cycle. The result comes out of a register one cycle after the input is presented. The input and the output each carry a valid strobe.

The block sorts each input into one of four ranges by comparing its magnitude bit pattern (the word with the sign bit cleared) against fixed limits:

- **Normal.** The 13 low mantissa bits are discarded with rounding, and the exponent is rebiased.
- **Subnormal.** Small magnitudes go through a separate right-shift-and-biased-add rounder. It produces half-precision subnormals directly, or the smallest normal when rounding carries into it.
- **Too large.** Finite magnitudes beyond the half-precision range become infinity.
- **NaN.** Every NaN collapses to one quiet-NaN code.

In all four cases the sign bit passes straight through.

Top module: `fp16_narrow_rne`

## Requirements
- R1: Output bit 15 equals input bit 31 for every accepted input, in all ranges.
- R2: An input whose magnitude (bits 30:0) is above 0x477FFFFF and at most 0x7F800000 yields output bits 14:0 = 0x7C00 (infinity).
- R3: An input whose magnitude is above 0x7F800000 (any NaN) yields output bits 14:0 = 0x7E00, whatever the NaN payload.
- R4: An input whose magnitude is at most 0x387FFFFF yields the half value nearest to it in units of 2^-24, with ties going to the even count. The result may round up to 0x0400, the smallest normal. Single-precision subnormals give zero.
- R5: +0 (0x00000000) gives 0x0000 and -0 (0x80000000) gives 0x8000.
- R6: A magnitude between 0x38800000 and 0x477FFFFF is rounded on its 13 discarded mantissa bits. The block rounds up when those bits exceed 0x1000, or equal 0x1000 and kept-mantissa bit 0 is 1. The exponent field is then reduced by 112.
- R7: A mantissa carry from rounding in the normal range increments the exponent. So 0x477FF000 (65520) gives 0x7C00, while 0x477FE000 (65504) gives 0x7BFF.
- R8: out_vld is in_vld delayed by exactly one clock. out_bits carries the result of the input accepted on the previous edge. out_bits keeps its value across cycles with in_vld low.
- R9: While rst is high, out_vld and out_bits are cleared to 0 at each clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Input word valid |
| in_bits | input | 32 | Single-precision input word |
| out_vld | output | 1 | Registered result valid |
| out_bits | output | 16 | Registered half-precision result |

## Verification
The hardest conditions to reach from the ports are exact halfway ties, and rounding carries that cross a boundary. A carry can cross from mantissa into exponent, from the largest finite value into infinity, or from the subnormal range into the smallest normal. Random stimulus almost never produces these.

The bench therefore builds input words bit by bit so that the discarded bits sit exactly on, just below or just above half an output LSB. It uses both odd and even kept LSBs, and covers the subnormal range at 2^-25 and 3·2^-25, as well as 0x387FFFFF and 0x477FF000. Back-to-back valid inputs, followed by idle cycles with changing input data, exercise the one-cycle timing and the hold behaviour.

// File: rtl/fp16_narrow_pkg.sv
package fp16_narrow_pkg;
  localparam int SRC_W     = 32;
  localparam int SRC_EXP_W = 8;
  localparam int SRC_MAN_W = 23;
  localparam int SRC_BIAS  = 127;
  localparam int DST_W     = 16;
  localparam int DST_EXP_W = 5;
  localparam int DST_MAN_W = 10;
  localparam int DST_BIAS  = 15;

  localparam int MAG_W   = SRC_W - 1;
  localparam int RES_W   = DST_W - 1;
  localparam int DROP_W  = SRC_MAN_W - DST_MAN_W;
  localparam int REBIAS  = SRC_BIAS - DST_BIAS;

  // Magnitude limits on the absolute bit pattern
  localparam logic [MAG_W-1:0] OVF_LIM =
    MAG_W'(((DST_BIAS + SRC_BIAS) << SRC_MAN_W) | ((1 << SRC_MAN_W) - 1));
  localparam logic [MAG_W-1:0] SUB_LIM =
    MAG_W'(((REBIAS + 1) << SRC_MAN_W) - 1);
  localparam logic [MAG_W-1:0] INF_MAG =
    MAG_W'(((1 << SRC_EXP_W) - 1) << SRC_MAN_W);

  // Half-precision special codes (magnitude part)
  localparam logic [RES_W-1:0] H_INF  = RES_W'(((1 << DST_EXP_W) - 1) << DST_MAN_W);
  localparam logic [RES_W-1:0] H_QNAN = H_INF | RES_W'(1 << (DST_MAN_W - 1));

  typedef enum logic [1:0] {
    RC_NORM = 2'd0,
    RC_SUB  = 2'd1,
    RC_INF  = 2'd2,
    RC_NAN  = 2'd3
  } rng_cls_t;
endpackage

// File: rtl/fp16n_classify.sv
module fp16n_classify
  import fp16_narrow_pkg::*;
(
  input  logic [MAG_W-1:0] mag,
  output rng_cls_t         cls
);
  always_comb begin
    if (mag > INF_MAG)       cls = RC_NAN;
    else if (mag > OVF_LIM)  cls = RC_INF;
    else if (mag <= SUB_LIM) cls = RC_SUB;
    else                     cls = RC_NORM;
  end
endmodule

// File: rtl/fp16n_norm_round.sv
module fp16n_norm_round
  import fp16_narrow_pkg::*;
(
  input  logic [MAG_W-1:0] mag,
  output logic [RES_W-1:0] res
);
  localparam int WORK_W = SRC_W;
  localparam logic [WORK_W-1:0] HALF_M1 = WORK_W'((1 << (DROP_W - 1)) - 1);
  localparam logic [WORK_W-1:0] EXP_ADJ = WORK_W'(REBIAS << DST_MAN_W);

  logic [WORK_W-1:0] sum;
  logic [WORK_W-1:0] kept;
  logic [WORK_W-1:0] rebiased;

  // Biased add: half-LSB minus one, plus kept LSB, gives ties-to-even
  always_comb begin
    sum      = {1'b0, mag} + HALF_M1 + WORK_W'(mag[DROP_W]);
    kept     = sum >> DROP_W;
    rebiased = kept - EXP_ADJ;
    res      = rebiased[RES_W-1:0];
  end
endmodule

// File: rtl/fp16n_sub_round.sv
module fp16n_sub_round
  import fp16_narrow_pkg::*;
(
  input  logic [MAG_W-1:0] mag,
  output logic [RES_W-1:0] res
);
  localparam int WORK_W = SRC_W;
  // Right shift that maps a significand onto units of the smallest half subnormal
  localparam int SH0    = SRC_BIAS + SRC_MAN_W + 1 - DST_BIAS - DST_MAN_W;
  localparam int SH_MAX = SRC_MAN_W + 2;
  localparam int SH_W   = $clog2(SH_MAX + 1);

  logic [SRC_EXP_W-1:0] ex;
  logic [WORK_W-1:0]    sig;
  logic [WORK_W-1:0]    bias;
  logic [WORK_W-1:0]    sum;
  logic [WORK_W-1:0]    shifted;
  logic [SH_W-1:0]      shc;
  int                   sh;

  always_comb begin
    ex  = mag[MAG_W-1 -: SRC_EXP_W];
    sig = {{(WORK_W-SRC_MAN_W-1){1'b0}}, (ex != '0), mag[SRC_MAN_W-1:0]};
    sh  = SH0 - ((ex == '0) ? 1 : int'(ex));
    if (sh > SH_MAX) sh = SH_MAX;
    shc     = SH_W'(sh);
    bias    = ((WORK_W'(1) << shc) >> 1) - WORK_W'(1) + WORK_W'(sig[shc]);
    sum     = sig + bias;
    shifted = sum >> shc;
    res     = shifted[RES_W-1:0];
  end
endmodule

// File: rtl/fp16_narrow_rne.sv
module fp16_narrow_rne
  import fp16_narrow_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             in_vld,
  input  logic [SRC_W-1:0] in_bits,
  output logic             out_vld,
  output logic [DST_W-1:0] out_bits
);
  logic [MAG_W-1:0] mag;
  logic             sgn;
  rng_cls_t         cls;
  logic [RES_W-1:0] norm_res;
  logic [RES_W-1:0] sub_res;
  logic [RES_W-1:0] sel_res;

  assign mag = in_bits[MAG_W-1:0];
  assign sgn = in_bits[SRC_W-1];

  fp16n_classify   u_cls  (.mag(mag), .cls(cls));
  fp16n_norm_round u_norm (.mag(mag), .res(norm_res));
  fp16n_sub_round  u_sub  (.mag(mag), .res(sub_res));

  always_comb begin
    unique case (cls)
      RC_NAN:  sel_res = H_QNAN;
      RC_INF:  sel_res = H_INF;
      RC_SUB:  sel_res = sub_res;
      default: sel_res = norm_res;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld  <= 1'b0;
      out_bits <= '0;
    end else begin
      out_vld <= in_vld;
      if (in_vld) out_bits <= {sgn, sel_res};
    end
  end
endmodule

// File: rtl/fp16_narrow_rne_chk.sv
module fp16_narrow_rne_chk (
  input logic        clk,
  input logic        rst,
  input logic        in_vld,
  input logic [31:0] in_bits,
  input logic        out_vld,
  input logic [15:0] out_bits
);
  logic [30:0] m;
  assign m = in_bits[30:0];

  AST_VLD_RISE: assert property (@(posedge clk) disable iff (rst)
    in_vld |=> out_vld); // R8
  AST_VLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !in_vld |=> !out_vld); // R8
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !in_vld |=> $stable(out_bits)); // R8
  AST_SIGN_PASS: assert property (@(posedge clk) disable iff (rst)
    in_vld |=> out_bits[15] == $past(in_bits[31])); // R1
  AST_OVF_INF: assert property (@(posedge clk) disable iff (rst)
    (in_vld && m > 31'h477FFFFF && m <= 31'h7F800000) |=> out_bits[14:0] == 15'h7C00); // R2
  AST_NAN_QUIET: assert property (@(posedge clk) disable iff (rst)
    (in_vld && m > 31'h7F800000) |=> out_bits[14:0] == 15'h7E00); // R3
  AST_SUB_RANGE: assert property (@(posedge clk) disable iff (rst)
    (in_vld && m <= 31'h387FFFFF) |=> out_bits[14:0] <= 15'h0400); // R4
  AST_ZERO_MAP: assert property (@(posedge clk) disable iff (rst)
    (in_vld && m == 31'h0) |=> out_bits[14:0] == 15'h0000); // R5
  AST_NORM_RANGE: assert property (@(posedge clk) disable iff (rst)
    (in_vld && m > 31'h387FFFFF && m <= 31'h477FFFFF)
      |=> (out_bits[14:0] >= 15'h0400 && out_bits[14:0] <= 15'h7C00)); // R6
endmodule

bind fp16_narrow_rne fp16_narrow_rne_chk chk_i (
  .clk(clk), .rst(rst), .in_vld(in_vld), .in_bits(in_bits),
  .out_vld(out_vld), .out_bits(out_bits)
);

// File: tb/fp16_narrow_rne_tb.sv
module fp16_narrow_rne_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_CYCLES = 5000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_vld = 1'b0;
  logic [31:0] in_bits = '0;
  logic        out_vld;
  logic [15:0] out_bits;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fp16_narrow_rne dut_i (
    .clk(clk), .rst(rst), .in_vld(in_vld), .in_bits(in_bits),
    .out_vld(out_vld), .out_bits(out_bits)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Present one word, check result one edge later
  task automatic conv(input string req, input logic [31:0] x, input logic [15:0] exp);
    @(negedge clk);
    in_vld  = 1'b1;
    in_bits = x;
    @(negedge clk);
    in_vld  = 1'b0;
    check({req, " valid"}, 32'(out_vld), 32'd1);
    check(req, 32'(out_bits), 32'(exp));
  endtask

  task automatic t_reset();
    rst = 1'b1;
    in_vld = 1'b1;
    in_bits = 32'h3F800000;
    repeat (3) @(negedge clk);
    check("R9 reset out_vld", 32'(out_vld), 32'd0);
    check("R9 reset out_bits", 32'(out_bits), 32'd0);
    in_vld = 1'b0;
    rst = 1'b0;
  endtask

  task automatic t_normal();
    conv("R6 one", 32'h3F800000, 16'h3C00);
    conv("R6 minus two", 32'hC0000000, 16'hC000);
    conv("R6 tie even down", 32'h3F801000, 16'h3C00);
    conv("R6 tie odd up", 32'h3F803000, 16'h3C02);
    conv("R6 above half", 32'h3F801001, 16'h3C01);
    conv("R6 below half", 32'h3F802FFF, 16'h3C01);
    conv("R6 min normal", 32'h38800000, 16'h0400);
    conv("R6 max finite", 32'h477FE000, 16'h7BFF);
    conv("R6 max finite below tie", 32'h477FEFFF, 16'h7BFF);
  endtask

  task automatic t_carry();
    conv("R7 carry into exponent", 32'h3F7FF000, 16'h3C00);
    conv("R7 65520 to inf", 32'h477FF000, 16'h7C00);
    conv("R7 limit to inf", 32'h477FFFFF, 16'h7C00);
    conv("R7 neg 65520", 32'hC77FF000, 16'hFC00);
  endtask

  task automatic t_overflow();
    conv("R2 65536", 32'h47800000, 16'h7C00);
    conv("R2 neg 65536", 32'hC7800000, 16'hFC00);
    conv("R2 flt max", 32'h7F7FFFFF, 16'h7C00);
    conv("R2 inf", 32'h7F800000, 16'h7C00);
    conv("R2 neg inf", 32'hFF800000, 16'hFC00);
  endtask

  task automatic t_nan();
    conv("R3 qnan", 32'h7FC00000, 16'h7E00);
    conv("R3 snan min payload", 32'h7F800001, 16'h7E00);
    conv("R3 neg nan", 32'hFFFFFFFF, 16'hFE00);
  endtask

  task automatic t_subnormal();
    conv("R4 2^-15", 32'h38000000, 16'h0200);
    conv("R4 neg 2^-15", 32'hB8000000, 16'h8200);
    conv("R4 2^-24", 32'h33800000, 16'h0001);
    conv("R4 2^-25 tie to zero", 32'h33000000, 16'h0000);
    conv("R4 above 2^-25", 32'h33000001, 16'h0001);
    conv("R4 3x2^-25 tie to two", 32'h33C00000, 16'h0002);
    conv("R4 round into normal", 32'h387FFFFF, 16'h0400);
    conv("R4 largest exact sub", 32'h387FC000, 16'h03FF);
    conv("R4 fp32 subnormal", 32'h00000001, 16'h0000);
    conv("R4 neg fp32 subnormal", 32'h80000001, 16'h8000);
  endtask

  task automatic t_zero();
    conv("R5 plus zero", 32'h00000000, 16'h0000);
    conv("R5 minus zero", 32'h80000000, 16'h8000);
    conv("R1 sign on one", 32'hBF800000, 16'hBC00);
  endtask

  task automatic t_stream();
    @(negedge clk);
    in_vld = 1'b1; in_bits = 32'h40000000;
    @(negedge clk);
    in_bits = 32'hC0400000;
    check("R8 stream first", 32'(out_bits), 32'h4000);
    @(negedge clk);
    in_vld = 1'b0; in_bits = 32'h3F800000;
    check("R8 stream second", 32'(out_bits), 32'hC200);
    check("R8 stream second valid", 32'(out_vld), 32'd1);
    @(negedge clk);
    in_bits = 32'h7FC00000;
    check("R8 idle valid low", 32'(out_vld), 32'd0);
    check("R8 idle hold", 32'(out_bits), 32'hC200);
    @(negedge clk);
    check("R8 idle hold again", 32'(out_bits), 32'hC200);
  endtask

  initial begin
    t_reset();
    t_normal();
    t_carry();
    t_overflow();
    t_nan();
    t_subnormal();
    t_zero();
    t_stream();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (WDOG_CYCLES) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual %0d cycles expected completion", WDOG_CYCLES);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
      $finish;
    end
  end
endmodule